// File: doc/BRIEF.md
# Multi-Lane Stream Integrity Checker

This block watches the receive side of a striped streaming link. Each beat carries one 64-bit sample word per lane. Every word holds three fields: a lane tag, a burst counter and a word counter. The checker confirms four things. Each word arrived on the right lane. Each lane's counters move forward in the expected way. The burst counter follows the start-of-burst strobe. All lanes of a beat carry the same counters, which shows that lane de-skew upstream worked.

Faults fall into three classes: lane swap, lane sequence and lane alignment. Each class has its own sticky flag and its own saturating counter. The block also keeps a saturating count of checked words and gives a pass indication. It is placed after the deframer and runs in the user clock domain.

Top module: `lane_stream_checker`

## Requirements
- R1: A beat is accepted when `en` and `rx_valid` are both high. Lane l occupies `rx_data[l*64 +: 64]`. In each lane word, bits 63:59 hold the lane tag, bits 58:32 the burst counter and bits 31:0 the word counter. On an accepted beat, a lane whose tag is not l is a lane swap fault.
- R2: On an accepted beat, for a seeded lane, a word counter that is not strictly greater (unsigned) than that lane's stored word counter is a lane sequence fault. A gap in the counter is not a fault.
- R3: On an accepted beat, for a seeded lane, a lane sequence fault is also raised in two cases. With `rx_sob` high, the burst counter is not strictly greater than the stored one. With `rx_sob` low, the burst counter differs from the stored one.
- R4: On an accepted beat, a lane l ≥ 1 whose word counter or burst counter differs from that of lane l-1 is a lane alignment fault.
- R5: A lane becomes unseeded after reset and on any cycle with `en` low. The first accepted beat after that only stores the counters and is exempt from the R2 and R3 checks. Every accepted beat stores the received counters, whether or not it is faulty.
- R6: Cycles that are not accepted beats change no stored counters, flags or counts.
- R7: Error flags stay set until `rst` or `clr_err`. `clr_err` zeroes all flags and error counters, and it wins over a fault in the same cycle.
- R8: Each error counter adds one per accepted beat that has at least one fault of its class. It holds at its all-ones value instead of wrapping.
- R9: A beat with faults of several classes raises every matching flag and counter in the same cycle.
- R10: After reset, every output is zero. `words_checked` adds LANES per accepted beat and saturates at its all-ones value. `clr_err` does not change it. `pass` is high when `words_checked` is non-zero and no flag is set.
- R11: The flags, counters and `words_checked` show the effect of a beat immediately after the clock edge that accepts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | User clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Checking enable; low unseeds all lanes |
| clr_err | input | 1 | Clears flags and error counters |
| rx_valid | input | 1 | Beat valid |
| rx_sob | input | 1 | Start of burst for this beat |
| rx_data | input | LANES*64 | Lane words, lane 0 in the low bits |
| swap_err | output | 1 | Sticky lane swap flag |
| seq_err | output | 1 | Sticky lane sequence flag |
| align_err | output | 1 | Sticky lane alignment flag |
| swap_errs | output | ERR_CNT_W | Saturating lane swap beat count |
| seq_errs | output | ERR_CNT_W | Saturating lane sequence beat count |
| align_errs | output | ERR_CNT_W | Saturating lane alignment beat count |
| words_checked | output | CHK_W | Saturating count of checked words |
| pass | output | 1 | Words checked and no flag set |

## Verification
The bench builds the block with four lanes, so a swap can involve inner lanes and alignment is compared across three adjacent pairs. A 3-bit error counter width lets the counters saturate after a handful of faulty beats. An 8-bit checked-word count reaches its ceiling within 64 beats, which makes the add-LANES step overshoot the limit, so the clamp is exercised rather than assumed.

// File: rtl/lsc_pkg.sv
package lsc_pkg;
  localparam int WORD_W = 64;
  localparam int TAG_W  = 5;
  localparam int BST_W  = 27;
  localparam int WCT_W  = 32;

  // field order follows bit order 63..0 of a lane word
  typedef struct packed {
    logic [TAG_W-1:0] tag;
    logic [BST_W-1:0] burst;
    logic [WCT_W-1:0] wcnt;
  } lane_word_t;
endpackage

// File: rtl/lsc_lane_track.sv
module lsc_lane_track
  import lsc_pkg::*;
#(
  parameter int LANE_IDX = 0
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       en,
  input  logic       beat,
  input  logic       sob,
  input  lane_word_t word,
  output logic       swap_fault,
  output logic       seq_fault
);
  localparam logic [TAG_W-1:0] MY_TAG = TAG_W'(LANE_IDX);

  logic [BST_W-1:0] burst_q;
  logic [WCT_W-1:0] wcnt_q;
  logic             seeded_q;
  logic             wcnt_bad;
  logic             burst_bad;

  always_ff @(posedge clk) begin
    if (rst) begin
      burst_q  <= '0;
      wcnt_q   <= '0;
      seeded_q <= 1'b0;
    end else if (!en) begin
      seeded_q <= 1'b0;
    end else if (beat) begin
      burst_q  <= word.burst;
      wcnt_q   <= word.wcnt;
      seeded_q <= 1'b1;
    end
  end

  always_comb begin
    wcnt_bad  = (word.wcnt <= wcnt_q);
    burst_bad = sob ? (word.burst <= burst_q) : (word.burst != burst_q);
  end

  assign swap_fault = beat && (word.tag != MY_TAG);
  assign seq_fault  = beat && seeded_q && (wcnt_bad || burst_bad);

  // R5
  no_seed_no_seq_chk: assert property (@(posedge clk) disable iff (rst)
    !seeded_q |-> !seq_fault);

  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !beat |=> ($stable(wcnt_q) && $stable(burst_q)));

  // R5
  reseed_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> !seeded_q);
endmodule

// File: rtl/lsc_err_accum.sv
module lsc_err_accum #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             hit,
  output logic             flag,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      flag <= 1'b0;
      cnt  <= '0;
    end else if (hit) begin
      flag <= 1'b1;
      if (cnt != CNT_MAX) cnt <= cnt + CNT_W'(1);
    end
  end

  // R7
  sticky_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (flag && !clr) |=> flag);

  // R7
  clear_wins_chk: assert property (@(posedge clk) disable iff (rst)
    clr |=> (!flag && cnt == '0));

  // R8
  sat_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (hit && !clr && cnt == CNT_MAX) |=> (cnt == CNT_MAX));

  // R8
  step_one_chk: assert property (@(posedge clk) disable iff (rst)
    (hit && !clr && cnt != CNT_MAX) |=> (cnt == $past(cnt) + CNT_W'(1)));
endmodule

// File: rtl/lane_stream_checker.sv
module lane_stream_checker
  import lsc_pkg::*;
#(
  parameter int LANES     = 2,
  parameter int ERR_CNT_W = 16,
  parameter int CHK_W     = 32
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    en,
  input  logic                    clr_err,
  input  logic                    rx_valid,
  input  logic                    rx_sob,
  input  logic [LANES*WORD_W-1:0] rx_data,
  output logic                    swap_err,
  output logic                    seq_err,
  output logic                    align_err,
  output logic [ERR_CNT_W-1:0]    swap_errs,
  output logic [ERR_CNT_W-1:0]    seq_errs,
  output logic [ERR_CNT_W-1:0]    align_errs,
  output logic [CHK_W-1:0]        words_checked,
  output logic                    pass
);
  localparam logic [CHK_W-1:0] CHK_MAX  = '1;
  localparam logic [CHK_W-1:0] CHK_STEP = CHK_W'(LANES);
  localparam logic [CHK_W-1:0] CHK_EDGE = CHK_MAX - CHK_STEP;

  logic             beat;
  lane_word_t       lane_w [LANES];
  logic [LANES-1:0] swap_lane;
  logic [LANES-1:0] seq_lane;
  logic [LANES-1:0] align_lane;
  logic             swap_hit;
  logic             seq_hit;
  logic             align_hit;

  assign beat = en && rx_valid;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign lane_w[l] = lane_word_t'(rx_data[l*WORD_W +: WORD_W]);

    lsc_lane_track #(.LANE_IDX(l)) u_track (
      .clk        (clk),
      .rst        (rst),
      .en         (en),
      .beat       (beat),
      .sob        (rx_sob),
      .word       (lane_w[l]),
      .swap_fault (swap_lane[l]),
      .seq_fault  (seq_lane[l])
    );

    if (l == 0) begin : g_first
      assign align_lane[l] = 1'b0;
    end else begin : g_pair
      assign align_lane[l] = beat &&
        ((lane_w[l].wcnt != lane_w[l-1].wcnt) || (lane_w[l].burst != lane_w[l-1].burst));
    end
  end

  assign swap_hit  = |swap_lane;
  assign seq_hit   = |seq_lane;
  assign align_hit = |align_lane;

  lsc_err_accum #(.CNT_W(ERR_CNT_W)) u_swap_acc (
    .clk(clk), .rst(rst), .clr(clr_err), .hit(swap_hit),
    .flag(swap_err), .cnt(swap_errs)
  );

  lsc_err_accum #(.CNT_W(ERR_CNT_W)) u_seq_acc (
    .clk(clk), .rst(rst), .clr(clr_err), .hit(seq_hit),
    .flag(seq_err), .cnt(seq_errs)
  );

  lsc_err_accum #(.CNT_W(ERR_CNT_W)) u_align_acc (
    .clk(clk), .rst(rst), .clr(clr_err), .hit(align_hit),
    .flag(align_err), .cnt(align_errs)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      words_checked <= '0;
    end else if (beat) begin
      if (words_checked > CHK_EDGE) words_checked <= CHK_MAX;
      else                          words_checked <= words_checked + CHK_STEP;
    end
  end

  assign pass = (words_checked != '0) && !(swap_err || seq_err || align_err);

  // R10
  words_mono_chk: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (words_checked >= $past(words_checked)));

  // R10
  pass_drop_chk: assert property (@(posedge clk) disable iff (rst)
    ((swap_hit || seq_hit || align_hit) && !clr_err) |=> !pass);

  // R6
  idle_count_chk: assert property (@(posedge clk) disable iff (rst)
    !beat |=> $stable(words_checked));
endmodule

// File: tb/lane_stream_checker_test.sv
`timescale 1ns/1ps
module lane_stream_checker_test;
  localparam int NL  = 4;
  localparam int ECW = 3;
  localparam int CW  = 8;
  localparam int DW  = NL*64;
  localparam int EMAX = (1 << ECW) - 1;
  localparam int CMAX = (1 << CW) - 1;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst, en, clr_err, rx_valid, rx_sob;
  logic [DW-1:0] rx_data;
  logic          swap_err, seq_err, align_err, pass;
  logic [ECW-1:0] swap_errs, seq_errs, align_errs;
  logic [CW-1:0]  words_checked;

  lane_stream_checker #(.LANES(NL), .ERR_CNT_W(ECW), .CHK_W(CW)) uut (
    .clk(clk), .rst(rst), .en(en), .clr_err(clr_err),
    .rx_valid(rx_valid), .rx_sob(rx_sob), .rx_data(rx_data),
    .swap_err(swap_err), .seq_err(seq_err), .align_err(align_err),
    .swap_errs(swap_errs), .seq_errs(seq_errs), .align_errs(align_errs),
    .words_checked(words_checked), .pass(pass)
  );

  // behavioural reference state
  logic [31:0] m_w [NL];
  logic [26:0] m_b [NL];
  bit          m_seed [NL];
  bit m_sf, m_qf, m_af;
  int m_sc, m_qc, m_ac, m_wc;
  int n_chk = 0, n_fail = 0;
  int gw, gb;

  function automatic logic [63:0] mkw(int tag, int b, int w);
    return {tag[4:0], b[26:0], w[31:0]};
  endfunction

  function automatic logic [DW-1:0] mkbeat(int b, int w);
    logic [DW-1:0] d;
    for (int l = 0; l < NL; l++) d[l*64 +: 64] = mkw(l, b, w);
    return d;
  endfunction

  task automatic model();
    bit beat, sw, sq, al;
    logic [63:0] wd, pw;
    if (rst) begin
      for (int l = 0; l < NL; l++) begin m_w[l] = '0; m_b[l] = '0; m_seed[l] = 0; end
      m_sf = 0; m_qf = 0; m_af = 0; m_sc = 0; m_qc = 0; m_ac = 0; m_wc = 0;
      return;
    end
    beat = en && rx_valid;
    sw = 0; sq = 0; al = 0;
    if (beat) begin
      for (int l = 0; l < NL; l++) begin
        wd = rx_data[l*64 +: 64];
        if (wd[63:59] != l[4:0]) sw = 1;
        if (m_seed[l]) begin
          if (wd[31:0] <= m_w[l]) sq = 1;
          if (rx_sob && wd[58:32] <= m_b[l]) sq = 1;
          if (!rx_sob && wd[58:32] != m_b[l]) sq = 1;
        end
        if (l > 0) begin
          pw = rx_data[(l-1)*64 +: 64];
          if (wd[58:0] != pw[58:0]) al = 1;
        end
      end
    end
    if (clr_err) begin
      m_sf = 0; m_qf = 0; m_af = 0; m_sc = 0; m_qc = 0; m_ac = 0;
    end else begin
      if (sw) begin m_sf = 1; if (m_sc < EMAX) m_sc++; end
      if (sq) begin m_qf = 1; if (m_qc < EMAX) m_qc++; end
      if (al) begin m_af = 1; if (m_ac < EMAX) m_ac++; end
    end
    if (beat) m_wc = (m_wc + NL > CMAX) ? CMAX : m_wc + NL;
    for (int l = 0; l < NL; l++) begin
      if (!en) m_seed[l] = 0;
      else if (beat) begin
        wd = rx_data[l*64 +: 64];
        m_w[l] = wd[31:0]; m_b[l] = wd[58:32]; m_seed[l] = 1;
      end
    end
  endtask

  task automatic chk(string tag, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compare(string tag);
    bit ep;
    ep = (m_wc != 0) && !(m_sf || m_qf || m_af);
    chk(tag, "swap_err",      int'(swap_err),      int'(m_sf));
    chk(tag, "seq_err",       int'(seq_err),       int'(m_qf));
    chk(tag, "align_err",     int'(align_err),     int'(m_af));
    chk(tag, "swap_errs",     int'(swap_errs),     m_sc);
    chk(tag, "seq_errs",      int'(seq_errs),      m_qc);
    chk(tag, "align_errs",    int'(align_errs),    m_ac);
    chk(tag, "words_checked", int'(words_checked), m_wc);
    chk(tag, "pass",          int'(pass),          int'(ep));
  endtask

  // inputs are set at a negedge; results are compared at the following negedge
  task automatic step(string tag);
    @(posedge clk);
    model();
    @(negedge clk);
    compare(tag);
  endtask

  task automatic good(bit sob, string tag);
    gw++;
    rx_valid = 1; rx_sob = sob; rx_data = mkbeat(gb, gw);
    step(tag);
  endtask

  task automatic clear();
    clr_err = 1; rx_valid = 0; rx_sob = 0;
    step("R7");
    clr_err = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst = 1; en = 0; clr_err = 0; rx_valid = 0; rx_sob = 0; rx_data = '0;
    step("R10"); step("R10");
    rst = 0; en = 1; gb = 1; gw = 0;

    // R11 / R2: clean burst, first beat seeds
    good(1, "R11");
    for (int i = 0; i < 4; i++) good(0, "R2");

    // R6: idle cycles with junk data
    rx_valid = 0; rx_sob = 1; rx_data = {NL{64'hFFFF_0000_0000_0001}};
    for (int i = 0; i < 3; i++) step("R6");

    // R3: a new burst followed by continuation beats
    gb++; good(1, "R3"); good(0, "R3"); good(0, "R3");

    // R1: lanes 1 and 2 swapped, then flag stays set
    gw++; rx_valid = 1; rx_sob = 0; rx_data = mkbeat(gb, gw);
    rx_data[64 +: 64] = mkw(2, gb, gw); rx_data[128 +: 64] = mkw(1, gb, gw);
    step("R1");
    good(0, "R7");
    clear();

    // R4: lane 3 lags by one word
    gw++; rx_valid = 1; rx_sob = 0; rx_data = mkbeat(gb, gw);
    rx_data[192 +: 64] = mkw(3, gb, gw - 1);
    step("R4");
    good(0, "R4");
    clear();

    // R2: gap is fine, repeat is not
    gw++; good(0, "R2");
    rx_valid = 1; rx_sob = 0; rx_data = mkbeat(gb, gw);
    step("R2");
    clear();

    // R3: burst changes without strobe, then strobe without change
    gw++; rx_valid = 1; rx_sob = 0; rx_data = mkbeat(gb + 1, gw);
    step("R3");
    gb++; gw++; rx_sob = 1; rx_data = mkbeat(gb, gw);
    step("R3");
    clear();

    // R9: swap, alignment and sequence faults in one beat
    gw++; rx_valid = 1; rx_sob = 1; rx_data = mkbeat(gb, gw);
    rx_data[128 +: 64] = mkw(0, gb, gw);
    rx_data[64 +: 64]  = mkw(1, gb, gw + 5);
    step("R9");
    clear();

    // R8: counter saturation
    for (int i = 0; i < 10; i++) begin
      gw++; rx_valid = 1; rx_sob = 0; rx_data = mkbeat(gb, gw);
      rx_data[0 +: 64] = mkw(3, gb, gw);
      step("R8");
    end
    clear();

    // R5: disable unseeds; lower counters accepted as a fresh start
    en = 0; rx_valid = 1; rx_sob = 0; rx_data = mkbeat(gb + 9, gw + 9);
    step("R5");
    en = 1; gw = 3; good(0, "R5"); good(0, "R5");

    // R10: checked-word count saturation
    for (int i = 0; i < 70; i++) good(0, "R10");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule